// File: doc/BRIEF.md
# Stretchable External Memory Access Sequencer

This block connects a simple CPU data-memory request port to a slower external RAM bus. Each accepted read or write turns into one bus access. The access has an address-valid window and a read or write strobe. Their widths, counted in CPU clock cycles, come from a 3-bit stretch value held in a configuration register. Software can write that register and read it back.

The CPU side presents a request, a direction, an address and write data. The sequencer latches all of them on acceptance and stalls the CPU while the window runs. It then returns read data together with a one-cycle done pulse. Reads, writes and the window each take their width from their own function of the stretch value. The write strobe sits inside the window and never starts in the window's first cycle.

Top module: `xmem_stretch_seq`

## Requirements
- R1: The stretch register is 3 bits wide and resets to 1. A write on the configuration port loads it, and its value is always visible on the readback port.
- R2: For a read with stretch s, the address-valid window and the read strobe both last s+1 cycles.
- R3: For a write with stretch s, the address-valid window lasts s+2 cycles.
- R4: For a write, the write strobe lasts 1 cycle when s is 0 or 1, and s cycles when s is 2 through 7.
- R5: The write strobe lies wholly inside the address-valid window and is low in the window's first cycle.
- R6: The external address and write data hold the values latched at acceptance for every cycle of the window.
- R7: Read data is captured from the external bus in the last read-strobe cycle. It appears on the CPU read-data output in the cycle that done is high.
- R8: Stall is high in every window cycle and low otherwise. Done is high for exactly one cycle, the cycle right after the window's last cycle.
- R9: A stretch-register write made during an access does not change that access. It takes effect from the next access onward.
- R10: Read and write strobes are never high in the same cycle. A request made while an access is in progress is ignored and produces no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Access request, taken when not stalled |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | AW | Access address |
| cpuWdata | input | DW | Write data |
| cpuRdata | output | DW | Captured read data |
| cpuStall | output | 1 | Access in progress |
| cpuDone | output | 1 | One-cycle completion pulse |
| cfgWe | input | 1 | Stretch register write enable |
| cfgWdata | input | SW | New stretch value |
| cfgRdata | output | SW | Stretch register readback |
| extAddr | output | AW | External address |
| extAddrValid | output | 1 | Address-valid window |
| extRd | output | 1 | Read strobe, active high |
| extWr | output | 1 | Write strobe, active high |
| extWdata | output | DW | External write data |
| extRdata | input | DW | External read data |

## Verification
The bench uses the default parameters: 8-bit address, 8-bit data and a 3-bit stretch field. With a 3-bit field, all eight stretch values can be tried for both reads and writes. That includes the write-strobe floor at stretch 0 and 1, and the longest window of nine cycles. The 8-bit data width allows distinct patterns per location, so a misplaced capture shows up as a wrong value. Injecting a stretch write and a second request mid-access checks that the current access is left alone.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  // Strobes from the control FSM to the datapath and bus pins.
  typedef struct packed {
    logic load;       // latch request fields
    logic capture;    // sample external read data
    logic addrValid;  // window active
    logic rdStb;
    logic wrStb;
    logic done;
  } xmemCtl_t;
endpackage

// File: rtl/xmem_ctl.sv
module xmem_ctl
  import xmem_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWe,
  input  logic [SW-1:0] cfgStretch,
  output xmemCtl_t      ctl
);
  localparam int CW = SW + 1;

  logic          busy;
  logic          isWr;
  logic          doneQ;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lastIdx;
  logic [CW-1:0] wrLast;
  logic          accept;
  logic          lastCycle;
  logic [CW-1:0] lastIdxNext;
  logic [CW-1:0] wrLastNext;

  assign accept    = !busy && cpuReq;
  assign lastCycle = busy && (cnt == lastIdx);

  always_comb begin
    // Window length minus one: read s, write s+1.
    lastIdxNext = CW'(cfgStretch) + (cpuWe ? CW'(1) : CW'(0));
    // Write strobe width with a floor of one cycle.
    wrLastNext  = (cfgStretch == '0) ? CW'(1) : CW'(cfgStretch);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      isWr    <= 1'b0;
      doneQ   <= 1'b0;
      cnt     <= '0;
      lastIdx <= '0;
      wrLast  <= '0;
    end else begin
      doneQ <= lastCycle;
      if (accept) begin
        busy    <= 1'b1;
        isWr    <= cpuWe;
        cnt     <= '0;
        lastIdx <= lastIdxNext;
        wrLast  <= wrLastNext;
      end else if (lastCycle) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_comb begin
    ctl.load      = accept;
    ctl.addrValid = busy;
    ctl.rdStb     = busy && !isWr;
    ctl.wrStb     = busy && isWr && (cnt >= CW'(1)) && (cnt <= wrLast);
    ctl.capture   = busy && !isWr && lastCycle;
    ctl.done      = doneQ;
  end
endmodule

// File: rtl/xmem_dp.sv
module xmem_dp
  import xmem_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SW          = 3,
  parameter int RST_STRETCH = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  xmemCtl_t      ctl,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  input  logic          cfgWe,
  input  logic [SW-1:0] cfgWdata,
  input  logic [DW-1:0] extRdata,
  output logic [SW-1:0] stretch,
  output logic [AW-1:0] addrQ,
  output logic [DW-1:0] wdataQ,
  output logic [DW-1:0] rdataQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stretch <= SW'(RST_STRETCH);
      addrQ   <= '0;
      wdataQ  <= '0;
      rdataQ  <= '0;
    end else begin
      if (cfgWe)       stretch <= cfgWdata;
      if (ctl.load)    begin
        addrQ  <= cpuAddr;
        wdataQ <= cpuWdata;
      end
      if (ctl.capture) rdataQ <= extRdata;
    end
  end
endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
  import xmem_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SW          = 3,
  parameter int RST_STRETCH = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWe,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic [DW-1:0] cpuRdata,
  output logic          cpuStall,
  output logic          cpuDone,
  input  logic          cfgWe,
  input  logic [SW-1:0] cfgWdata,
  output logic [SW-1:0] cfgRdata,
  output logic [AW-1:0] extAddr,
  output logic          extAddrValid,
  output logic          extRd,
  output logic          extWr,
  output logic [DW-1:0] extWdata,
  input  logic [DW-1:0] extRdata
);
  xmemCtl_t      ctl;
  logic [SW-1:0] stretch;

  xmem_ctl #(.SW(SW)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .cpuWe     (cpuWe),
    .cfgStretch(stretch),
    .ctl       (ctl)
  );

  xmem_dp #(.AW(AW), .DW(DW), .SW(SW), .RST_STRETCH(RST_STRETCH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .cpuAddr (cpuAddr),
    .cpuWdata(cpuWdata),
    .cfgWe   (cfgWe),
    .cfgWdata(cfgWdata),
    .extRdata(extRdata),
    .stretch (stretch),
    .addrQ   (extAddr),
    .wdataQ  (extWdata),
    .rdataQ  (cpuRdata)
  );

  assign cpuStall     = ctl.addrValid;
  assign cpuDone      = ctl.done;
  assign cfgRdata     = stretch;
  assign extAddrValid = ctl.addrValid;
  assign extRd        = ctl.rdStb;
  assign extWr        = ctl.wrStb;
endmodule

// File: rtl/xmem_stretch_chk.sv
module xmem_stretch_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuStall,
  input logic          cpuDone,
  input logic [AW-1:0] extAddr,
  input logic          extAddrValid,
  input logic          extRd,
  input logic          extWr,
  input logic [DW-1:0] extWdata
);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(extRd && extWr));

  assert_wr_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    extWr |-> extAddrValid);

  assert_rd_in_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    extRd |-> extAddrValid);

  assert_wr_not_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extAddrValid) |-> !extWr);

  assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (extAddrValid && $past(extAddrValid)) |-> ($stable(extAddr) && $stable(extWdata)));

  assert_done_after_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> (!cpuStall && $past(cpuStall)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);
endmodule

bind xmem_stretch_seq xmem_stretch_chk #(.AW(AW), .DW(DW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .cpuStall    (cpuStall),
  .cpuDone     (cpuDone),
  .extAddr     (extAddr),
  .extAddrValid(extAddrValid),
  .extRd       (extRd),
  .extWr       (extWr),
  .extWdata    (extWdata)
);

// File: tb/tb_xmem_stretch_seq.sv
module tb_xmem_stretch_seq;
  logic       clk = 1'b0;
  logic       rstN;
  logic       cpuReq, cpuWe, cfgWe;
  logic [7:0] cpuAddr, cpuWdata, cpuRdata, extAddr, extWdata, extRdata;
  logic       cpuStall, cpuDone, extAddrValid, extRd, extWr;
  logic [2:0] cfgWdata, cfgRdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  xmem_stretch_seq dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuStall(cpuStall), .cpuDone(cpuDone),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .extAddr(extAddr),
    .extAddrValid(extAddrValid), .extRd(extRd), .extWr(extWr), .extWdata(extWdata),
    .extRdata(extRdata)
  );

  // External RAM model
  logic [7:0] mem [256];
  always @(posedge clk) if (extWr) mem[extAddr] <= extWdata;
  assign extRdata = mem[extAddr];

  // Bus monitor
  logic clrMon = 1'b0;
  int   avCnt, rdCnt, wrCnt, stallCnt, wrStart, rises;
  bit   unstable, overlap, prevAv;
  logic [7:0] firstAddr, firstWd;
  always @(posedge clk) begin
    if (clrMon) begin
      avCnt = 0; rdCnt = 0; wrCnt = 0; stallCnt = 0; wrStart = -1;
      rises = 0; unstable = 0; overlap = 0;
    end else begin
      if (extAddrValid) begin
        if (!prevAv) rises++;
        if (avCnt == 0) begin firstAddr = extAddr; firstWd = extWdata; end
        else if (extAddr != firstAddr || extWdata != firstWd) unstable = 1;
        if (extWr && wrStart < 0) wrStart = avCnt;
        avCnt++;
      end
      if (extRd) rdCnt++;
      if (extWr) wrCnt++;
      if (cpuStall) stallCnt++;
      if (extRd && extWr) overlap = 1;
    end
    prevAv = extAddrValid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  function automatic int expAv(input bit we, input int s);
    return we ? s + 2 : s + 1;
  endfunction
  function automatic int expStb(input bit we, input int s);
    return we ? ((s < 2) ? 1 : s) : s + 1;
  endfunction

  // One access; checks widths, placement, stability, stall, done, read data.
  // injReq: a second request mid-access; injCfg: stretch write of 7 mid-access.
  task automatic access(input bit we, input int s, input logic [7:0] a,
                        input logic [7:0] d, input bit injReq, input bit injCfg);
    int cyc;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d; clrMon = 1'b1;
    @(negedge clk);
    cpuReq = 1'b0; clrMon = 1'b0;
    cyc = 0;
    while (!cpuDone && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) begin
        if (injReq) begin cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = a + 8'd1; cpuWdata = 8'h00; end
        if (injCfg) begin cfgWe = 1'b1; cfgWdata = 3'd7; end
      end
      if (cyc == 3) begin cpuReq = 1'b0; cfgWe = 1'b0; end
    end
    cpuReq = 1'b0; cfgWe = 1'b0;
    check(cpuDone == 1'b1, "R8 done seen", cpuDone, 1);
    check(avCnt == expAv(we, s), we ? "R3 write window" : "R2 read window", avCnt, expAv(we, s));
    if (we) begin
      check(wrCnt == expStb(1, s), "R4 write strobe width", wrCnt, expStb(1, s));
      check(rdCnt == 0, "R10 no read strobe on write", rdCnt, 0);
      check(wrStart >= 1 && wrStart + wrCnt <= avCnt, "R5 strobe placement", wrStart, 1);
    end else begin
      check(rdCnt == expStb(0, s), "R2 read strobe width", rdCnt, expStb(0, s));
      check(wrCnt == 0, "R10 no write strobe on read", wrCnt, 0);
      check(cpuRdata == d, "R7 read data", cpuRdata, d);
    end
    check(!unstable && firstAddr == a, "R6 bus stable", firstAddr, a);
    if (we) check(firstWd == d, "R6 write data", firstWd, d);
    check(!overlap, "R10 strobe overlap", overlap, 0);
    check(stallCnt == avCnt && !cpuStall, "R8 stall span", stallCnt, avCnt);
    check(rises == 1, "R10 single access", rises, 1);
    @(negedge clk);
    check(cpuDone == 1'b0, "R8 done one cycle", cpuDone, 0);
  endtask

  // {we, stretch, addr, data}: writes at every stretch, then reads back.
  localparam logic [19:0] VEC [16] = '{
    {1'b1, 3'd0, 8'h10, 8'h3C}, {1'b1, 3'd1, 8'h11, 8'hC3},
    {1'b1, 3'd2, 8'h12, 8'h5A}, {1'b1, 3'd3, 8'h13, 8'hA5},
    {1'b1, 3'd4, 8'h14, 8'h0F}, {1'b1, 3'd5, 8'h15, 8'hF0},
    {1'b1, 3'd6, 8'h16, 8'h99}, {1'b1, 3'd7, 8'h17, 8'h66},
    {1'b0, 3'd7, 8'h10, 8'h3C}, {1'b0, 3'd6, 8'h11, 8'hC3},
    {1'b0, 3'd5, 8'h12, 8'h5A}, {1'b0, 3'd4, 8'h13, 8'hA5},
    {1'b0, 3'd3, 8'h14, 8'h0F}, {1'b0, 3'd2, 8'h15, 8'hF0},
    {1'b0, 3'd1, 8'h16, 8'h99}, {1'b0, 3'd0, 8'h17, 8'h66}
  };

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cpuReq = 1'b0; cpuWe = 1'b0; cpuAddr = '0; cpuWdata = '0;
    cfgWe = 1'b0; cfgWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    check(cfgRdata == 3'd1, "R1 reset stretch", cfgRdata, 1);
    check(!cpuStall && !cpuDone, "R8 idle after reset", cpuStall, 0);
    check(!extAddrValid && !extRd && !extWr, "R10 bus idle after reset", extAddrValid, 0);

    // Default stretch 1 without any configuration write
    access(1'b1, 1, 8'h30, 8'h77, 1'b0, 1'b0);
    access(1'b0, 1, 8'h30, 8'h77, 1'b0, 1'b0);

    for (int i = 0; i < 16; i++) begin
      cfgWrite(VEC[i][18:16]);
      check(cfgRdata == VEC[i][18:16], "R1 readback", cfgRdata, VEC[i][18:16]);
      access(VEC[i][19], int'(VEC[i][18:16]), VEC[i][15:8], VEC[i][7:0], 1'b0, 1'b0);
    end

    // R9: stretch change mid-write leaves the current access at stretch 2
    cfgWrite(3'd2);
    access(1'b1, 2, 8'h40, 8'hE1, 1'b0, 1'b1);
    check(cfgRdata == 3'd7, "R9 new value stored", cfgRdata, 7);
    access(1'b0, 7, 8'h40, 8'hE1, 1'b0, 1'b0);

    // R10: request during a busy read is ignored; its target keeps old data
    cfgWrite(3'd3);
    access(1'b0, 3, 8'h10, 8'h3C, 1'b1, 1'b0);
    access(1'b0, 3, 8'h11, 8'hC3, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule